// File: doc/BRIEF.md
# Cycle-Stealing Multi-Channel DMA Controller

This block moves blocks of bytes between I/O devices and memory without the processor copying each byte. It has four channels, and each channel has a request input from its device and an acknowledge output back to it. Software gives each channel a start address, a transfer count and a mode, and then sets the channel's enable bit. When an enabled channel raises its request, the controller asks the processor for the buses with a hold request. It waits for the hold acknowledge. It then steals one transfer's worth of bus cycles and hands the buses back.

A transfer takes one of two forms. In the single-cycle direct form, the memory strobe and the device strobe fire in the same cycle and the data never enters the controller. In the two-cycle form, the byte is captured in an internal data register and then driven out on the data bus. After each transfer the channel's current address steps up by one and its current count steps down by one. When the count wraps to all ones, the following happens:

- The channel flags completion.
- The interrupt output goes high.
- The channel disables itself.
- The current registers reload from the base registers, ready for the next block.

Bus drivers are modelled as output-enable signals, not as pads.

Top module: `dma_cycle_steal`

## Requirements
- R1: After a synchronous active-low reset, the following are all low: `hold_req`, `dack`, every output enable, every strobe and `irq`. The enable and status registers read zero.
- R2: Register select `cfg_sel` is {global bit [4], channel [3:2], field [1:0]}. For a channel, field 0 is the address, field 1 is the count and field 2 is the mode. Writing the address or count field loads both the base and the current register. Reading either field returns the current value. Global select 5'b10000 is the enable register, one bit per channel. Global select 5'b10001 is the completion status register.
- R3: A request from a channel whose enable bit is clear is ignored. `hold_req` stays low and the channel's registers are unchanged.
- R4: An enabled request raises `hold_req` one cycle later. `dack`, `addr_oe`, `ctrl_oe` and `data_oe` are asserted only in the cycles after `hold_ack` has been sampled high, and only while it stays high.
- R5: When several enabled channels request at the same time, the lowest-numbered channel is served first. At most one `dack` bit is high in any cycle.
- R6: Each transfer drives the channel's current address on `bus_addr`. Afterwards the current address increments by one, wrapping at the address width, and the current count decrements by one.
- R7: A transfer taken with current count 0 completes the block. It sets the channel's status bit, clears its enable bit and reloads its current address and count from the base values. A count of N therefore gives N+1 transfers.
- R8: Mode bit 1 = 0 selects the direct form. It uses one bus cycle with both a memory strobe and a device strobe, and `data_oe` stays low.
- R9: Mode bit 1 = 1 selects the two-cycle form. The first cycle reads the source and captures `data_in`. The second cycle asserts `data_oe` and drives the captured byte on `data_out` while strobing the destination.
- R10: Mode bit 0 = 1 means memory to device: memory is read (`mem_rd`) and the device is written (`io_wr`). Mode bit 0 = 0 means device to memory (`io_rd`, then `mem_wr`). Read and write strobes of the same target are never high together.
- R11: Every transfer has its own hold handshake. After the last bus cycle, `hold_req` falls. A new request is not raised until `hold_ack` has been seen low.
- R12: `irq` is the OR of the status bits. Writing the status register clears only the bits written as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 5 | Register select (global, channel, field) |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Read data for the selected register |
| dreq | input | 4 | Per-channel device request |
| dack | output | 4 | Per-channel device acknowledge |
| hold_req | output | 1 | Bus request to the processor |
| hold_ack | input | 1 | Bus grant from the processor |
| bus_addr | output | 16 | Memory address, zero when not driving |
| addr_oe | output | 1 | Address bus driver enable |
| ctrl_oe | output | 1 | Control bus driver enable |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Device read strobe |
| io_wr | output | 1 | Device write strobe |
| data_in | input | 8 | Data bus input for the two-cycle form |
| data_out | output | 8 | Captured byte for the deposit cycle |
| data_oe | output | 1 | Data bus driver enable |
| irq | output | 1 | Block-complete interrupt |

## Verification
The properties assume a well-behaved bus owner. Once `hold_ack` has answered `hold_req`, it stays high until the controller drops `hold_req`, and only then falls. The properties also assume that a channel's mode is not rewritten while that channel is in a transfer. The bench meets these assumptions with a processor model whose `hold_ack` only follows `hold_req`, after a latency that the test can set. All register writes happen while no transfer is in flight. Device requests are held steady until the block's completion bit is seen.

// File: rtl/dmac_pkg.sv
// Shared definitions for the cycle-stealing DMA controller.
// Assumes: register select field codes and mode bit positions below are
// the software-visible encoding.
package dmac_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HOLD    = 3'd1,
        ST_BUS_A   = 3'd2,
        ST_BUS_B   = 3'd3,
        ST_RELEASE = 3'd4
    } seq_state_e;

    localparam logic [1:0] FLD_ADDR  = 2'd0;
    localparam logic [1:0] FLD_COUNT = 2'd1;
    localparam logic [1:0] FLD_MODE  = 2'd2;

    localparam int MODE_TO_DEV  = 0;
    localparam int MODE_TWO_CYC = 1;
endpackage

// File: rtl/dmac_chan_regs.sv
// Per-channel register file: base/current address and count, mode,
// enable and completion status, plus the register read mux.
// Assumes: at most one transfer update per cycle; a register write in
// the same cycle as an update wins over it.
module dmac_chan_regs
    import dmac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int RW  = 16,
    parameter int CHW = 2,
    parameter int SELW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [SELW-1:0] sel,
    input  logic [RW-1:0]   wdata,
    output logic [RW-1:0]   rdata,
    input  logic            upd,
    input  logic [CHW-1:0]  upd_ch,
    input  logic [CHW-1:0]  view_ch,
    output logic [AW-1:0]   view_addr,
    output logic [NCH-1:0]  en,
    output logic [NCH-1:0]  to_dev,
    output logic [NCH-1:0]  two_cyc,
    output logic [NCH-1:0]  tc
);
    logic [AW-1:0] base_a [NCH];
    logic [AW-1:0] cur_a  [NCH];
    logic [CW-1:0] base_c [NCH];
    logic [CW-1:0] cur_c  [NCH];
    logic [1:0]    mode   [NCH];

    logic           is_glob;
    logic [CHW-1:0] wch;
    logic [1:0]     fld;
    logic           last_xfer;
    logic [NCH-1:0] tc_set;
    logic [NCH-1:0] tc_clr;

    assign is_glob   = sel[SELW-1];
    assign wch       = sel[CHW+1:2];
    assign fld       = sel[1:0];
    assign last_xfer = upd && (cur_c[upd_ch] == '0);
    assign view_addr = cur_a[view_ch];

    // Split each channel's mode into its direction and form bits.
    for (genvar g = 0; g < NCH; g++) begin : g_mode
        assign to_dev[g]  = mode[g][MODE_TO_DEV];
        assign two_cyc[g] = mode[g][MODE_TWO_CYC];
    end

    // Completion flag set and write-one-to-clear masks.
    always_comb begin
        tc_set = last_xfer ? (NCH'(1) << upd_ch) : '0;
        tc_clr = (wr && is_glob && sel[0]) ? wdata[NCH-1:0] : '0;
    end

    // Completion status register.
    always_ff @(posedge clk) begin
        if (!rst_n) tc <= '0;
        else        tc <= (tc | tc_set) & ~tc_clr;
    end

    // Address/count stepping, reload on completion, and software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= '0;
            for (int i = 0; i < NCH; i++) begin
                base_a[i] <= '0;
                cur_a[i]  <= '0;
                base_c[i] <= '0;
                cur_c[i]  <= '0;
                mode[i]   <= '0;
            end
        end else begin
            if (upd) begin
                if (last_xfer) begin
                    cur_a[upd_ch] <= base_a[upd_ch];
                    cur_c[upd_ch] <= base_c[upd_ch];
                    en[upd_ch]    <= 1'b0;
                end else begin
                    cur_a[upd_ch] <= cur_a[upd_ch] + AW'(1);
                    cur_c[upd_ch] <= cur_c[upd_ch] - CW'(1);
                end
            end
            if (wr) begin
                if (is_glob) begin
                    if (!sel[0]) en <= wdata[NCH-1:0];
                end else begin
                    case (fld)
                        FLD_ADDR: begin
                            base_a[wch] <= wdata[AW-1:0];
                            cur_a[wch]  <= wdata[AW-1:0];
                        end
                        FLD_COUNT: begin
                            base_c[wch] <= wdata[CW-1:0];
                            cur_c[wch]  <= wdata[CW-1:0];
                        end
                        FLD_MODE: mode[wch] <= wdata[1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    // Read mux for the selected register.
    always_comb begin
        rdata = '0;
        if (is_glob) begin
            rdata[NCH-1:0] = sel[0] ? tc : en;
        end else begin
            case (fld)
                FLD_ADDR:  rdata[AW-1:0] = cur_a[wch];
                FLD_COUNT: rdata[CW-1:0] = cur_c[wch];
                FLD_MODE:  rdata[1:0]    = mode[wch];
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dmac_prio_pick.sv
// Fixed-priority picker: reports whether any request is set and the
// index of the lowest-numbered one.
// Assumes: N >= 2.
module dmac_prio_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);
    // Scan from the top so the lowest set index is the one left behind.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/dmac_sequencer.sv
// Bus ownership sequencer: hold handshake, one transfer per grant,
// strobe generation for the direct and two-cycle forms.
// Assumes: hold_ack stays high from grant until hold_req falls.
module dmac_sequencer
    import dmac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CHW = 2,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_any,
    input  logic [CHW-1:0] req_idx,
    input  logic           hold_ack,
    input  logic           to_dev,
    input  logic           two_cyc,
    input  logic [DW-1:0]  data_in,
    output logic [CHW-1:0] cur_ch,
    output logic           upd,
    output logic           hold_req,
    output logic [NCH-1:0] dack,
    output logic           bus_on,
    output logic           data_oe,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           io_rd,
    output logic           io_wr,
    output logic [DW-1:0]  data_out
);
    seq_state_e state;
    logic       in_a;
    logic       in_b;

    assign in_a = (state == ST_BUS_A);
    assign in_b = (state == ST_BUS_B);

    // State, granted channel and data capture register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_ch   <= '0;
            data_out <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_any) state <= ST_HOLD;
                ST_HOLD: if (hold_ack) begin
                    if (req_any) begin
                        cur_ch <= req_idx;
                        state  <= ST_BUS_A;
                    end else begin
                        state <= ST_RELEASE;
                    end
                end
                ST_BUS_A: begin
                    if (two_cyc) begin
                        data_out <= data_in;
                        state    <= ST_BUS_B;
                    end else begin
                        state <= ST_RELEASE;
                    end
                end
                ST_BUS_B:   state <= ST_RELEASE;
                ST_RELEASE: if (!hold_ack) state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // Bus outputs decoded from the state and the granted channel's mode.
    always_comb begin
        bus_on   = in_a || in_b;
        hold_req = bus_on || (state == ST_HOLD);
        dack     = bus_on ? (NCH'(1) << cur_ch) : '0;
        data_oe  = in_b;
        upd      = (in_a && !two_cyc) || in_b;
        mem_rd   = in_a && to_dev;
        io_rd    = in_a && !to_dev;
        io_wr    = to_dev && ((in_a && !two_cyc) || in_b);
        mem_wr   = !to_dev && ((in_a && !two_cyc) || in_b);
    end
endmodule

// File: rtl/dma_cycle_steal.sv
// Top level of the cycle-stealing DMA controller: ties the register
// file, channel picker and bus sequencer together.
// Assumes: NCH >= 2; register writes do not target a channel mid-transfer.
module dma_cycle_steal #(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int CW  = 16,
    parameter int DW  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_wr,
    input  logic [$clog2(NCH)+2:0]        cfg_sel,
    input  logic [((AW>CW)?AW:CW)-1:0]    cfg_wdata,
    output logic [((AW>CW)?AW:CW)-1:0]    cfg_rdata,
    input  logic [NCH-1:0]                dreq,
    output logic [NCH-1:0]                dack,
    output logic                          hold_req,
    input  logic                          hold_ack,
    output logic [AW-1:0]                 bus_addr,
    output logic                          addr_oe,
    output logic                          ctrl_oe,
    output logic                          mem_rd,
    output logic                          mem_wr,
    output logic                          io_rd,
    output logic                          io_wr,
    input  logic [DW-1:0]                 data_in,
    output logic [DW-1:0]                 data_out,
    output logic                          data_oe,
    output logic                          irq
);
    localparam int CHW  = $clog2(NCH);
    localparam int SELW = CHW + 3;
    localparam int RW   = (AW > CW) ? AW : CW;

    logic [NCH-1:0] en;
    logic [NCH-1:0] to_dev;
    logic [NCH-1:0] two_cyc;
    logic [NCH-1:0] tc;
    logic           req_any;
    logic [CHW-1:0] req_idx;
    logic [CHW-1:0] cur_ch;
    logic           upd;
    logic           bus_on;
    logic [AW-1:0]  view_addr;

    dmac_chan_regs #(
        .NCH(NCH), .AW(AW), .CW(CW), .RW(RW), .CHW(CHW), .SELW(SELW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata), .rdata(cfg_rdata),
        .upd(upd), .upd_ch(cur_ch), .view_ch(cur_ch), .view_addr(view_addr),
        .en(en), .to_dev(to_dev), .two_cyc(two_cyc), .tc(tc)
    );

    dmac_prio_pick #(.N(NCH), .W(CHW)) u_pick (
        .req(dreq & en), .any(req_any), .idx(req_idx)
    );

    dmac_sequencer #(.NCH(NCH), .CHW(CHW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_any(req_any), .req_idx(req_idx), .hold_ack(hold_ack),
        .to_dev(to_dev[cur_ch]), .two_cyc(two_cyc[cur_ch]), .data_in(data_in),
        .cur_ch(cur_ch), .upd(upd), .hold_req(hold_req), .dack(dack),
        .bus_on(bus_on), .data_oe(data_oe),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
        .data_out(data_out)
    );

    // Address and control drivers follow bus ownership; address idles at zero.
    always_comb begin
        addr_oe  = bus_on;
        ctrl_oe  = bus_on;
        bus_addr = bus_on ? view_addr : '0;
        irq      = |tc;
    end
endmodule

// File: rtl/dma_cycle_steal_checker.sv
// Protocol checker for the DMA controller, attached by bind.
// Assumes: hold_ack is held by the bus owner as described in the brief.
module dma_cycle_steal_checker #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] dack,
    input logic           hold_req,
    input logic           hold_ack,
    input logic           addr_oe,
    input logic           ctrl_oe,
    input logic           data_oe,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic           io_rd,
    input logic           io_wr,
    input logic           irq
);
    assert_drive_needs_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_oe || ctrl_oe || data_oe) |-> hold_ack);

    assert_ack_with_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dack != '0) |-> (addr_oe && ctrl_oe));

    assert_single_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));

    assert_irq_after_transfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(addr_oe));

    assert_deposit_after_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> ($past(addr_oe) && !$past(data_oe)));

    assert_strobes_disjoint_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr) && !(io_rd && io_wr));

    assert_strobe_needs_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr || io_rd || io_wr) |-> addr_oe);

    assert_release_after_xfer_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_oe) |-> !hold_req);
endmodule

bind dma_cycle_steal dma_cycle_steal_checker #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .dack(dack), .hold_req(hold_req),
    .hold_ack(hold_ack), .addr_oe(addr_oe), .ctrl_oe(ctrl_oe),
    .data_oe(data_oe), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_rd(io_rd), .io_wr(io_wr), .irq(irq)
);

// File: tb/dma_cycle_steal_test.sv
`timescale 1ns/1ps
// Bench for the DMA controller: a behavioural reference model runs in
// step with the design and every output is compared on every cycle,
// alongside directed checks of each requirement.
module dma_cycle_steal_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [3:0]  dreq = '0;
    logic [3:0]  dack;
    logic        hold_req;
    logic        hold_ack = 1'b0;
    logic [15:0] bus_addr;
    logic        addr_oe, ctrl_oe, mem_rd, mem_wr, io_rd, io_wr, data_oe, irq;
    logic [7:0]  data_in = 8'h11;
    logic [7:0]  data_out;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;
    int ack_lat = 0;
    int ack_wait = 0;

    dma_cycle_steal uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq), .dack(dack),
        .hold_req(hold_req), .hold_ack(hold_ack), .bus_addr(bus_addr),
        .addr_oe(addr_oe), .ctrl_oe(ctrl_oe), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .io_rd(io_rd), .io_wr(io_wr), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Reference model state.
    int          m_state = 0;
    int          m_ch = 0;
    bit          m_valid = 0;
    logic [15:0] m_ba [4];
    logic [15:0] m_ca [4];
    logic [15:0] m_bc [4];
    logic [15:0] m_cc [4];
    logic [1:0]  m_mode [4];
    logic [3:0]  m_en, m_tc, m_elig;
    logic [7:0]  m_latch;
    int          m_win;
    bit          m_upd;

    // Reference model: advances once per rising edge from the sampled inputs.
    always @(posedge clk) begin
        m_valid = 1;
        if (!rst_n) begin
            m_state = 0; m_ch = 0; m_en = 0; m_tc = 0; m_latch = 0;
            for (int i = 0; i < 4; i++) begin
                m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0; m_mode[i] = 0;
            end
        end else begin
            m_elig = m_en & dreq;
            m_win = 0;
            for (int i = 3; i >= 0; i--) if (m_elig[i]) m_win = i;
            m_upd = 0;
            case (m_state)
                0: if (m_elig != 0) m_state = 1;
                1: if (hold_ack) begin
                       if (m_elig != 0) begin m_ch = m_win; m_state = 2; end
                       else m_state = 4;
                   end
                2: if (m_mode[m_ch][1]) begin m_latch = data_in; m_state = 3; end
                   else begin m_upd = 1; m_state = 4; end
                3: begin m_upd = 1; m_state = 4; end
                default: if (!hold_ack) m_state = 0;
            endcase
            if (m_upd) begin
                if (m_cc[m_ch] == 0) begin
                    m_ca[m_ch] = m_ba[m_ch]; m_cc[m_ch] = m_bc[m_ch];
                    m_en[m_ch] = 0; m_tc[m_ch] = 1;
                end else begin
                    m_ca[m_ch] = m_ca[m_ch] + 1; m_cc[m_ch] = m_cc[m_ch] - 1;
                end
            end
            if (cfg_wr) begin
                if (cfg_sel[4]) begin
                    if (cfg_sel[0]) m_tc = m_tc & ~cfg_wdata[3:0];
                    else            m_en = cfg_wdata[3:0];
                end else begin
                    case (cfg_sel[1:0])
                        2'd0: begin m_ba[cfg_sel[3:2]] = cfg_wdata; m_ca[cfg_sel[3:2]] = cfg_wdata; end
                        2'd1: begin m_bc[cfg_sel[3:2]] = cfg_wdata; m_cc[cfg_sel[3:2]] = cfg_wdata; end
                        2'd2: m_mode[cfg_sel[3:2]] = cfg_wdata[1:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    // Per-cycle comparison of every output against the model.
    always @(negedge clk) begin
        if (m_valid) begin
            bit inbus, todev, two;
            inbus = (m_state == 2) || (m_state == 3);
            todev = m_mode[m_ch][0];
            two   = m_mode[m_ch][1];
            chk("R11", hold_req, (m_state == 1) || inbus, "hold_req");
            chk("R5", dack, inbus ? (4'b1 << m_ch) : 4'b0, "dack");
            chk("R4", {addr_oe, ctrl_oe}, {inbus, inbus}, "addr_oe/ctrl_oe");
            chk("R6", bus_addr, inbus ? m_ca[m_ch] : 16'h0, "bus_addr");
            chk("R10", {mem_rd, mem_wr, io_rd, io_wr},
                {(m_state == 2) && todev,
                 !todev && (((m_state == 2) && !two) || (m_state == 3)),
                 (m_state == 2) && !todev,
                 todev && (((m_state == 2) && !two) || (m_state == 3))}, "strobes");
            chk("R9", data_oe, m_state == 3, "data_oe");
            if (m_state == 3) chk("R9", data_out, m_latch, "data_out");
            chk("R7", irq, |m_tc, "irq");
        end
    end

    // Processor model: hold_ack follows hold_req after ack_lat cycles.
    always @(negedge clk) begin
        if (hold_req !== hold_ack) begin
            if (ack_wait >= ack_lat) begin hold_ack = hold_req; ack_wait = 0; end
            else ack_wait++;
        end else ack_wait = 0;
        data_in = data_in + 8'h3B;
    end

    // Activity monitor: transfers, handshakes, bus cycles and address log.
    int      n_xfer = 0, n_hreq = 0, n_bus = 0, n_doe = 0;
    logic [3:0] prev_dack = 0;
    logic    prev_hreq = 0;
    int      ch_log[$];
    logic [15:0] addr_log[$];
    always @(negedge clk) begin
        if (dack != 0 && prev_dack == 0) begin
            n_xfer++;
            for (int i = 0; i < 4; i++) if (dack[i]) ch_log.push_back(i);
            addr_log.push_back(bus_addr);
        end
        if (hold_req && !prev_hreq) n_hreq++;
        if (addr_oe) n_bus++;
        if (data_oe) n_doe++;
        prev_dack = dack;
        prev_hreq = hold_req;
    end

    task automatic clear_log();
        n_xfer = 0; n_hreq = 0; n_bus = 0; n_doe = 0;
        ch_log.delete(); addr_log.delete();
    endtask

    task automatic wr(logic [4:0] s, logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] s, output logic [15:0] v);
        @(negedge clk);
        cfg_sel = s;
        #1 v = cfg_rdata;
    endtask

    task automatic wait_tc(logic [3:0] mask, string tag);
        logic [15:0] v;
        bit done = 0;
        for (int i = 0; i < 3000 && !done; i++) begin
            rd(5'b10001, v);
            if ((v[3:0] & mask) == mask) done = 1;
        end
        chk(tag, done, 1, "block completion seen");
        repeat (6) @(negedge clk);
    endtask

    function automatic logic [4:0] csel(int ch, int fld);
        return {1'b0, 2'(ch), 2'(fld)};
    endfunction

    localparam logic [4:0] SEL_EN = 5'b10000;
    localparam logic [4:0] SEL_ST = 5'b10001;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired (R1..): actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    logic [15:0] v;
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(SEL_EN, v); chk("R1", v, 0, "enable after reset");
        rd(SEL_ST, v); chk("R1", v, 0, "status after reset");
        chk("R1", {hold_req, dack, addr_oe, data_oe, irq}, 0, "outputs after reset");

        // R2: base writes load current registers
        wr(csel(1, 0), 16'h1000);
        wr(csel(1, 1), 16'd2);
        wr(csel(1, 2), 16'b01);
        rd(csel(1, 0), v); chk("R2", v, 16'h1000, "current address");
        rd(csel(1, 1), v); chk("R2", v, 16'd2, "current count");
        rd(csel(1, 2), v); chk("R2", v, 16'b01, "mode");

        // R3: disabled channel ignores its request
        dreq = 4'b0010;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); chk("R3", hold_req, 0, "hold_req while disabled");
        end
        rd(csel(1, 0), v); chk("R3", v, 16'h1000, "address untouched");

        // R8/R10/R6/R11/R7: direct form, memory to device, three transfers
        clear_log();
        wr(SEL_EN, 16'b0010);
        wait_tc(4'b0010, "R7");
        dreq = 0;
        chk("R6", n_xfer, 3, "transfers for count 2");
        chk("R11", n_hreq, 3, "one handshake per transfer");
        chk("R8", n_bus, 3, "one bus cycle per transfer");
        chk("R8", n_doe, 0, "no data drive in direct form");
        chk("R6", (addr_log.size() == 3) ? {addr_log[0], addr_log[2]} : 0,
            {16'h1000, 16'h1002}, "first/last address");
        rd(SEL_EN, v); chk("R7", v, 0, "enable cleared at completion");
        rd(csel(1, 0), v); chk("R7", v, 16'h1000, "address reloaded");
        rd(csel(1, 1), v); chk("R7", v, 16'd2, "count reloaded");
        chk("R12", irq, 1, "irq with status set");
        wr(SEL_ST, 16'b0010);
        rd(SEL_ST, v); chk("R12", v, 0, "status cleared");
        chk("R12", irq, 0, "irq after clear");

        // R5: simultaneous requests, slow processor grant
        ack_lat = 3;
        wr(csel(0, 0), 16'h2000); wr(csel(0, 1), 16'd0); wr(csel(0, 2), 16'b00);
        wr(csel(2, 0), 16'h3000); wr(csel(2, 1), 16'd0); wr(csel(2, 2), 16'b11);
        clear_log();
        wr(SEL_EN, 16'b0101);
        dreq = 4'b0101;
        wait_tc(4'b0101, "R5");
        dreq = 0;
        chk("R5", (ch_log.size() == 2) ? {ch_log[0][3:0], ch_log[1][3:0]} : 8'hFF,
            {4'd0, 4'd2}, "service order");
        wr(SEL_ST, 16'b0001);
        rd(SEL_ST, v); chk("R12", v, 16'b0100, "only written bit cleared");
        chk("R12", irq, 1, "irq held by remaining bit");
        wr(SEL_ST, 16'b0100);

        // R9/R10/R6: two-cycle form, device to memory, address wrap
        ack_lat = 1;
        wr(csel(3, 0), 16'hFFFF); wr(csel(3, 1), 16'd1); wr(csel(3, 2), 16'b10);
        clear_log();
        wr(SEL_EN, 16'b1000);
        dreq = 4'b1000;
        wait_tc(4'b1000, "R9");
        dreq = 0;
        chk("R9", n_bus, 4, "two bus cycles per transfer");
        chk("R9", n_doe, 2, "one deposit cycle per transfer");
        chk("R6", (addr_log.size() == 2) ? {addr_log[0], addr_log[1]} : 0,
            {16'hFFFF, 16'h0000}, "address wrap");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule